// File: doc/BRIEF.md
# Hall-Commutated Three-Phase Gate Logic

This block drives the six gate-enable lines of a three-phase bridge from three Hall-sensor logic levels. The sensors are spaced 120 electrical degrees apart. From each sensor code and the direction input, the block picks one phase to source current through its high-side switch and one phase to sink it through its low-side switch. The third phase floats. A chop input modulates the sourcing high-side switch. During the chop off-time, a decay-mode input selects the recirculation path. Slow decay keeps the sinking low-side switch on. Fast decay releases it as well. A synchronous-rectification enable turns on the switches whose body diodes would otherwise carry the recirculating current.

Every phase has its own dead-time counter, so the two switches of a half-bridge never conduct together. After either switch of a phase turns off, the counter restarts. Neither switch may turn on until the counter reaches a value programmed in clock cycles. The two sensor codes that cannot occur in a healthy motor (all zeros and all ones) raise a fault flag and release every gate. A brake input shorts the motor windings through the low-side switches. A halt input releases all gates.

Top module: `bldc_gate_ctrl`

## Requirements
- R1: With direction low, chop high, brake and halt low, the Hall codes {hall_i[2:0]} = 001, 011, 010, 110, 100, 101 drive the high-side and low-side phases (A=bit 0, B=bit 1, C=bit 2) A/B, A/C, B/C, B/A, C/A and C/B respectively. Only those two switches are on.
- R2: With direction high, every valid code swaps the roles: the phase that would have been high-side becomes low-side, and the other way round.
- R3: Codes 000 and 111 set hall_fault_o one clock edge after they are presented and force all six gates off. This takes precedence over brake.
- R4: In slow decay (fast_decay_i low) with synchronous rectification off, chop low turns off only the active high-side switch. The active low-side switch stays on.
- R5: In fast decay with synchronous rectification off, chop low turns off both the active high-side and the active low-side switch.
- R6: In slow decay with synchronous rectification on, chop low also turns on the low-side switch of the sourcing phase.
- R7: In fast decay with synchronous rectification on, chop low turns on the low-side switch of the sourcing phase and the high-side switch of the sinking phase.
- R8: A gate that is requested while its phase is settled turns off one clock edge after its request drops. A switch turns on no earlier than dead_cycles_i+1 clock edges after the last turn-off in its phase. When its request is already present, it turns on exactly then.
- R9: The high-side and low-side gates of one phase are never on at the same time.
- R10: Brake, with a valid code and halt low, turns all three low-side gates on and all high-side gates off.
- R11: Halt turns all six gates off regardless of brake and Hall code. The fault flag still follows the Hall code.
- R12: Asynchronous reset (rst_ni low) turns all gates off at once and clears the fault flag. After release, every dead-time counter starts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hall_i | input | 3 | Hall sensor levels, bit 0 = phase A |
| dir_i | input | 1 | Rotation direction, 1 = reverse |
| pwm_i | input | 1 | Chop request, 1 = on-time |
| fast_decay_i | input | 1 | 1 = fast decay, 0 = slow decay |
| sync_rect_i | input | 1 | Synchronous rectification enable |
| brake_i | input | 1 | Low-side brake |
| halt_i | input | 1 | Release all gates |
| dead_cycles_i | input | DEAD_W | Dead time in clock cycles |
| gate_hi_o | output | 3 | High-side gate enables, bit 0 = phase A |
| gate_lo_o | output | 3 | Low-side gate enables, bit 0 = phase A |
| hall_fault_o | output | 1 | Invalid Hall code seen |

## Verification
Turn-off decisions and the fault flag pass through exactly one register, so they are due on the first rising edge after the stimulus. A turn-on is due dead_cycles_i+1 edges after the last turn-off in that phase. Stimulus changes on the falling edge, and results are sampled 1 ns after a rising edge. Each table entry waits six edges with a one-cycle dead time so that every phase has settled. The directed dead-time test counts the edges one by one and confirms the gate is still off on the edge before it is due and on at the edge it is due.

// File: rtl/bldc_gate_pkg.sv
`timescale 1ns/1ps
package bldc_gate_pkg;
  localparam int NPH = 3;

  typedef logic [NPH-1:0] ph_mask_t;

  typedef struct packed {
    ph_mask_t hi;
    ph_mask_t lo;
    logic     valid;
  } commute_t;

  // bit 0 = A, bit 1 = B, bit 2 = C
  function automatic commute_t hall_lookup(input logic [2:0] code, input logic rev);
    commute_t c;
    c.valid = 1'b1;
    unique case (code)
      3'b001: begin c.hi = 3'b001; c.lo = 3'b010; end
      3'b011: begin c.hi = 3'b001; c.lo = 3'b100; end
      3'b010: begin c.hi = 3'b010; c.lo = 3'b100; end
      3'b110: begin c.hi = 3'b010; c.lo = 3'b001; end
      3'b100: begin c.hi = 3'b100; c.lo = 3'b001; end
      3'b101: begin c.hi = 3'b100; c.lo = 3'b010; end
      default: begin c.hi = '0; c.lo = '0; c.valid = 1'b0; end
    endcase
    if (rev) begin
      ph_mask_t t;
      t    = c.hi;
      c.hi = c.lo;
      c.lo = t;
    end
    return c;
  endfunction
endpackage

// File: rtl/bldc_hall_commutator.sv
`timescale 1ns/1ps
module bldc_hall_commutator
  import bldc_gate_pkg::*;
(
  input  logic [2:0] hall_i,
  input  logic       dir_i,
  output ph_mask_t   hi_ph_o,
  output ph_mask_t   lo_ph_o,
  output logic       invalid_o
);
  commute_t cmt;

  always_comb begin
    cmt       = hall_lookup(hall_i, dir_i);
    hi_ph_o   = cmt.hi;
    lo_ph_o   = cmt.lo;
    invalid_o = !cmt.valid;
  end

  always_comb begin
    if (!invalid_o) begin
      AST_PHASE_DISJOINT: assert ((hi_ph_o & lo_ph_o) == '0 && $onehot(hi_ph_o) && $onehot(lo_ph_o)); // R1
    end
  end
endmodule

// File: rtl/bldc_drive_request.sv
`timescale 1ns/1ps
module bldc_drive_request
  import bldc_gate_pkg::*;
(
  input  ph_mask_t hi_ph_i,
  input  ph_mask_t lo_ph_i,
  input  logic     invalid_i,
  input  logic     pwm_i,
  input  logic     fast_decay_i,
  input  logic     sync_rect_i,
  input  logic     brake_i,
  input  logic     halt_i,
  output ph_mask_t req_hi_o,
  output ph_mask_t req_lo_o
);
  for (genvar p = 0; p < NPH; p++) begin : g_ph
    always_comb begin
      if (halt_i || invalid_i) begin
        req_hi_o[p] = 1'b0;
        req_lo_o[p] = 1'b0;
      end else if (brake_i) begin
        req_hi_o[p] = 1'b0;
        req_lo_o[p] = 1'b1;
      end else begin
        // sourcing phase chops; sinking phase high side only rectifies in fast decay
        req_hi_o[p] = (hi_ph_i[p] & pwm_i)
                    | (lo_ph_i[p] & ~pwm_i & fast_decay_i & sync_rect_i);
        req_lo_o[p] = (lo_ph_i[p] & (pwm_i | ~fast_decay_i))
                    | (hi_ph_i[p] & ~pwm_i & sync_rect_i);
      end
    end

    always_comb begin
      AST_REQ_EXCLUSIVE: assert (!(req_hi_o[p] && req_lo_o[p])); // R9
    end
  end
endmodule

// File: rtl/bldc_dead_time.sv
`timescale 1ns/1ps
module bldc_dead_time #(
  parameter int DEAD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DEAD_W-1:0] dead_cycles_i,
  input  logic              req_hi_i,
  input  logic              req_lo_i,
  output logic              gate_hi_o,
  output logic              gate_lo_o
);
  localparam logic [DEAD_W-1:0] CNT_SAT = {DEAD_W{1'b1}};

  logic              hi_q, lo_q, hi_d, lo_d, gap_ok;
  logic [DEAD_W-1:0] cnt_q;

  always_comb begin
    gap_ok = !hi_q && !lo_q && (cnt_q >= dead_cycles_i);
    hi_d   = req_hi_i && (hi_q || (gap_ok && !req_lo_i));
    lo_d   = req_lo_i && (lo_q || (gap_ok && !req_hi_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q  <= 1'b0;
      lo_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      hi_q <= hi_d;
      lo_q <= lo_d;
      if (hi_q || lo_q)        cnt_q <= '0;
      else if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign gate_hi_o = hi_q;
  assign gate_lo_o = lo_q;

  AST_NO_SHOOT_THROUGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hi_q && lo_q)); // R9
  AST_HI_AFTER_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hi_q) |-> !$past(lo_q)); // R8
  AST_LO_AFTER_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lo_q) |-> !$past(hi_q)); // R8
  AST_HI_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(req_hi_i) |-> !hi_q); // R8
  AST_LO_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(req_lo_i) |-> !lo_q); // R8
endmodule

// File: rtl/bldc_gate_ctrl.sv
`timescale 1ns/1ps
module bldc_gate_ctrl
  import bldc_gate_pkg::*;
#(
  parameter int DEAD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        hall_i,
  input  logic              dir_i,
  input  logic              pwm_i,
  input  logic              fast_decay_i,
  input  logic              sync_rect_i,
  input  logic              brake_i,
  input  logic              halt_i,
  input  logic [DEAD_W-1:0] dead_cycles_i,
  output logic [2:0]        gate_hi_o,
  output logic [2:0]        gate_lo_o,
  output logic              hall_fault_o
);
  ph_mask_t hi_ph, lo_ph, req_hi, req_lo;
  logic     invalid, fault_q;

  bldc_hall_commutator u_cmt (
    .hall_i    (hall_i),
    .dir_i     (dir_i),
    .hi_ph_o   (hi_ph),
    .lo_ph_o   (lo_ph),
    .invalid_o (invalid)
  );

  bldc_drive_request u_req (
    .hi_ph_i      (hi_ph),
    .lo_ph_i      (lo_ph),
    .invalid_i    (invalid),
    .pwm_i        (pwm_i),
    .fast_decay_i (fast_decay_i),
    .sync_rect_i  (sync_rect_i),
    .brake_i      (brake_i),
    .halt_i       (halt_i),
    .req_hi_o     (req_hi),
    .req_lo_o     (req_lo)
  );

  for (genvar p = 0; p < NPH; p++) begin : g_dt
    bldc_dead_time #(.DEAD_W(DEAD_W)) u_dt (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .dead_cycles_i (dead_cycles_i),
      .req_hi_i      (req_hi[p]),
      .req_lo_i      (req_lo[p]),
      .gate_hi_o     (gate_hi_o[p]),
      .gate_lo_o     (gate_lo_o[p])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fault_q <= 1'b0;
    else         fault_q <= invalid;
  end

  assign hall_fault_o = fault_q;

  AST_FAULT_ALL_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hall_fault_o |-> (gate_hi_o == '0 && gate_lo_o == '0)); // R3
  AST_BRAKE_NO_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(brake_i) |-> gate_hi_o == '0); // R10
  AST_HALT_ALL_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(halt_i) |-> (gate_hi_o == '0 && gate_lo_o == '0)); // R11
  AST_ONE_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(gate_hi_o) <= 1); // R1
endmodule

// File: tb/bldc_gate_ctrl_tb.sv
`timescale 1ns/1ps
module bldc_gate_ctrl_tb;
  localparam real PERIOD = 8.0;
  localparam int  DEAD_W = 8;
  localparam int  NVEC   = 20;

  // {hall[2:0], dir, pwm, fast, sr, brake, halt, hi[2:0], lo[2:0], fault}
  localparam logic [15:0] VEC [NVEC] = '{
    16'b001_0_1_0_0_0_0_001_010_0,
    16'b011_0_1_0_0_0_0_001_100_0,
    16'b010_0_1_0_0_0_0_010_100_0,
    16'b110_0_1_0_0_0_0_010_001_0,
    16'b100_0_1_0_0_0_0_100_001_0,
    16'b101_0_1_0_0_0_0_100_010_0,
    16'b001_1_1_0_0_0_0_010_001_0,
    16'b110_1_1_0_0_0_0_001_010_0,
    16'b100_1_1_0_0_0_0_001_100_0,
    16'b000_0_1_0_0_0_0_000_000_1,
    16'b111_0_1_0_0_0_0_000_000_1,
    16'b001_0_0_0_0_0_0_000_010_0,
    16'b001_0_0_1_0_0_0_000_000_0,
    16'b001_0_0_0_1_0_0_000_011_0,
    16'b001_0_0_1_1_0_0_010_001_0,
    16'b010_0_1_1_1_0_0_010_100_0,
    16'b011_0_1_0_0_1_0_000_111_0,
    16'b111_0_1_0_0_1_0_000_000_1,
    16'b011_0_1_0_0_1_1_000_000_0,
    16'b101_0_1_0_0_0_1_000_000_0
  };

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [2:0]        hall_i = 3'b001;
  logic              dir_i = 1'b0, pwm_i = 1'b0, fast_decay_i = 1'b0, sync_rect_i = 1'b0;
  logic              brake_i = 1'b0, halt_i = 1'b0;
  logic [DEAD_W-1:0] dead_cycles_i = 8'd1;
  logic [2:0]        gate_hi_o, gate_lo_o;
  logic              hall_fault_o;

  int checks = 0, fails = 0;
  logic overlap_seen = 1'b0;
  logic finished = 1'b0;

  bldc_gate_ctrl #(.DEAD_W(DEAD_W)) u_dut (
    .clk_i, .rst_ni, .hall_i, .dir_i, .pwm_i, .fast_decay_i, .sync_rect_i,
    .brake_i, .halt_i, .dead_cycles_i, .gate_hi_o, .gate_lo_o, .hall_fault_o
  );

  always #(PERIOD/2) clk_i = ~clk_i;

  always @(negedge clk_i)
    if (rst_ni && (gate_hi_o & gate_lo_o) != 3'b000) overlap_seen = 1'b1;

  task automatic chk(input string req, input logic [6:0] exp);
    logic [6:0] act;
    act = {gate_hi_o, gate_lo_o, hall_fault_o};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {hi,lo,fault} actual %b expected %b", req, act, exp);
    end
  endtask

  function automatic string req_of(input int i);
    if (i < 6 || i == 15) return "R1";
    if (i < 9)            return "R2";
    if (i < 11 || i == 17) return "R3";
    if (i == 11)          return "R4";
    if (i == 12)          return "R5";
    if (i == 13)          return "R6";
    if (i == 14)          return "R7";
    if (i == 16)          return "R10";
    return "R11";
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R12 reset state
    #3;
    chk("R12", 7'b000_000_0);
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk_i);
      {hall_i, dir_i, pwm_i, fast_decay_i, sync_rect_i, brake_i, halt_i} = VEC[i][15:7];
      repeat (6) @(posedge clk_i);
      #1 chk(req_of(i), VEC[i][6:0]);
    end

    // R12 asynchronous reset mid-run, then dead-time restart
    @(negedge clk_i);
    {hall_i, dir_i, pwm_i, fast_decay_i, sync_rect_i, brake_i, halt_i} = 9'b001_0_1_0_0_0_0;
    repeat (6) @(posedge clk_i);
    #2 rst_ni = 1'b0;
    #1 chk("R12", 7'b000_000_0);
    @(negedge clk_i) rst_ni = 1'b1;
    @(posedge clk_i); #1 chk("R12", 7'b000_000_0);
    @(posedge clk_i); #1 chk("R12", 7'b001_010_0);

    // R8 dead time of three cycles, fast decay with rectification
    @(negedge clk_i);
    dead_cycles_i = 8'd3;
    fast_decay_i  = 1'b1;
    sync_rect_i   = 1'b1;
    repeat (10) @(posedge clk_i);
    #1 chk("R8", 7'b001_010_0);
    @(negedge clk_i) pwm_i = 1'b0;
    @(posedge clk_i); #1 chk("R8", 7'b000_000_0);
    repeat (3) @(posedge clk_i);
    #1 chk("R8", 7'b000_000_0);
    @(posedge clk_i); #1 chk("R8", 7'b010_001_0);
    @(negedge clk_i) pwm_i = 1'b1;
    @(posedge clk_i); #1 chk("R8", 7'b000_000_0);
    repeat (3) @(posedge clk_i);
    #1 chk("R8", 7'b000_000_0);
    @(posedge clk_i); #1 chk("R8", 7'b001_010_0);

    // R9 no phase ever had both gates on
    checks++;
    if (overlap_seen) begin
      fails++;
      $display("FAIL R9: overlap actual 1 expected 0");
    end

    finish_run();
  end
endmodule